// File: doc/BRIEF.md
# Memory Tag Checking Unit

This block sits between a load/store pipeline and a small data store. It holds a 4-bit version tag for each 64-byte block. Each access carries its own tag in the top four address bits. When checking is active, the block compares that tag with the stored one. A matching access goes through. A mismatch raises a trap: either precise, reported with the faulting address, or deferred, recorded with the PC of the first offending store and held until software acknowledges it. Software writes tags through a tag-set request, and clears a block's tag and data with a block-initializing store.

Every request receives a registered response in the following cycle. The response carries load data and an optional trap with a 2-bit type and an address. Deferred store mismatches are not reported in the response. They set a sticky record, which appears on its own pair of outputs.

Top module: `memtag_unit`

## Requirements
- R1: After reset all stored tags and data are zero, no deferred record is pending, and every response and trap output is zero.
- R2: A request presented at a clock edge gets resp_valid at the next edge. A load that does not trap returns the stored word on resp_rdata. trap_valid is never high without resp_valid.
- R3: Tag comparison happens only when task_chk_en and page_chk_en are both high. Otherwise loads and stores never trap.
- R4: A tag of 0x0 or 0xF on either side (address bits 63:60 or the stored tag) matches any tag.
- R5: A load whose tag mismatches returns trap_type 1 with trap_addr equal to the request address and resp_rdata 0. This holds whatever precise_mode is.
- R6: With precise_mode low, a store whose tag mismatches still writes its data, raises no response trap, and records its req_pc as a deferred mismatch (dfr_pending high).
- R7: With precise_mode high, a store whose tag mismatches is suppressed and returns trap_type 1 with its address.
- R8: A non-faulting load (req_nofault high) is never compared and never traps.
- R9: A tag-set writes req_wdata[3:0] as the tag of exactly one block. The block is indexed by address bits 9:6, and the address tag bits play no part in the index.
- R10: A tag-set while task_chk_en is low writes nothing and returns trap_type 2.
- R11: A tag-set while task_chk_en is high and page_writable is low writes nothing and returns trap_type 3.
- R12: A block-initializing store is not compared. It clears both the tag and the data word of its block.
- R13: While dfr_pending is high, later deferred mismatches leave dfr_pc unchanged. dfr_ack clears the record, except that a deferred mismatch in the same cycle as dfr_ack becomes the new record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Address; bits 63:60 hold the access tag |
| req_store | input | 1 | Store when high, load when low |
| req_tagset | input | 1 | Tag-set request (highest precedence) |
| req_blkinit | input | 1 | Block-initializing store (next precedence) |
| req_nofault | input | 1 | Load is non-faulting |
| req_wdata | input | 32 | Store data; low 4 bits are the tag for tag-set |
| req_pc | input | 64 | PC of the requesting instruction |
| task_chk_en | input | 1 | Per-task tag checking enable |
| page_chk_en | input | 1 | Per-page tag checking enable |
| page_writable | input | 1 | Page allows writes |
| precise_mode | input | 1 | Store mismatches trap precisely |
| dfr_ack | input | 1 | Software acknowledge of the deferred record |
| resp_valid | output | 1 | Request completed |
| resp_rdata | output | 32 | Load data |
| trap_valid | output | 1 | Response carries a trap |
| trap_type | output | 2 | 1 mismatch, 2 tagging disabled, 3 tag-set on read-only page |
| trap_addr | output | 64 | Faulting address |
| dfr_pending | output | 1 | Deferred mismatch recorded |
| dfr_pc | output | 64 | PC of the recorded deferred mismatch |

## Verification
Two functions can meet in one cycle: a deferred store mismatch that would capture a new record, and software's acknowledge of the old record. The bench raises a record, keeps it while further mismatching stores arrive, then issues a mismatching store with dfr_ack high. It expects the new PC to be held afterwards, neither a cleared record nor the old PC. A behavioural model that tracks every tag and data word is compared with all outputs on every clock.

// File: rtl/memtag_unit.sv
module memtag_unit #(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 4,
  parameter int BLK_BYTES = 64,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_store,
  input  logic              req_tagset,
  input  logic              req_blkinit,
  input  logic              req_nofault,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic              task_chk_en,
  input  logic              page_chk_en,
  input  logic              page_writable,
  input  logic              precise_mode,
  input  logic              dfr_ack,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              trap_valid,
  output logic [1:0]        trap_type,
  output logic [ADDR_W-1:0] trap_addr,
  output logic              dfr_pending,
  output logic [ADDR_W-1:0] dfr_pc
);
  localparam int OFF_W   = $clog2(BLK_BYTES);
  localparam int DEPTH   = 1 << IDX_W;
  localparam int TAG_LSB = ADDR_W - TAG_W;
  localparam logic [TAG_W-1:0] WILD_LO = '0;
  localparam logic [TAG_W-1:0] WILD_HI = '1;
  localparam logic [1:0] TT_NONE = 2'd0, TT_MISMATCH = 2'd1, TT_TAGOFF = 2'd2, TT_RDONLY = 2'd3;

  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] atag, stag;
  logic is_set, is_init, is_st, is_ld;
  logic chk_on, wild, mism;
  logic ld_trap, st_prec, st_dfr, set_off, set_ro, set_ok, any_trap, capture;

  assign idx     = req_addr[OFF_W +: IDX_W];
  assign atag    = req_addr[TAG_LSB +: TAG_W];
  assign stag    = tag_mem[idx];
  assign is_set  = req_tagset;
  assign is_init = !req_tagset && req_blkinit;
  assign is_st   = !req_tagset && !req_blkinit && req_store;
  assign is_ld   = !req_tagset && !req_blkinit && !req_store;
  assign chk_on  = task_chk_en && page_chk_en;
  assign wild    = (atag == WILD_LO) || (atag == WILD_HI) || (stag == WILD_LO) || (stag == WILD_HI);
  assign mism    = chk_on && !wild && (atag != stag);
  assign ld_trap = is_ld && !req_nofault && mism;
  assign st_prec = is_st && mism && precise_mode;
  assign st_dfr  = is_st && mism && !precise_mode;
  assign set_off = is_set && !task_chk_en;
  assign set_ro  = is_set && task_chk_en && !page_writable;
  assign set_ok  = is_set && task_chk_en && page_writable;
  assign any_trap = ld_trap || st_prec || set_off || set_ro;
  assign capture  = req_valid && st_dfr && (!dfr_pending || dfr_ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_rdata  <= '0;
      trap_valid  <= 1'b0;
      trap_type   <= TT_NONE;
      trap_addr   <= '0;
      dfr_pending <= 1'b0;
      dfr_pc      <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_mem[i]  <= '0;
        data_mem[i] <= '0;
      end
    end else begin
      resp_valid <= req_valid;
      trap_valid <= req_valid && any_trap;
      trap_addr  <= (req_valid && any_trap) ? req_addr : '0;
      resp_rdata <= (req_valid && is_ld && !ld_trap) ? data_mem[idx] : '0;
      if (!req_valid)   trap_type <= TT_NONE;
      else if (set_off) trap_type <= TT_TAGOFF;
      else if (set_ro)  trap_type <= TT_RDONLY;
      else if (ld_trap || st_prec) trap_type <= TT_MISMATCH;
      else              trap_type <= TT_NONE;
      if (req_valid) begin
        if (set_ok) tag_mem[idx] <= req_wdata[TAG_W-1:0];
        if (is_init) begin
          tag_mem[idx]  <= '0;
          data_mem[idx] <= '0;
        end
        if (is_st && !st_prec) data_mem[idx] <= req_wdata;
      end
      if (capture) begin
        dfr_pending <= 1'b1;
        dfr_pc      <= req_pc;
      end else if (dfr_ack) begin
        dfr_pending <= 1'b0;
      end
    end
  end

  assert_trap_in_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> resp_valid);

  assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && !$past(req_tagset) && !($past(task_chk_en) && $past(page_chk_en)))
    |-> !trap_valid);

  assert_wildcard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && !$past(req_tagset) &&
     (($past(req_addr[TAG_LSB +: TAG_W]) == WILD_LO) || ($past(req_addr[TAG_LSB +: TAG_W]) == WILD_HI)))
    |-> !trap_valid);

  assert_nofault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && !$past(req_tagset) && !$past(req_blkinit) && !$past(req_store) && $past(req_nofault))
    |-> !trap_valid);

  assert_tagoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && $past(req_tagset) && !$past(task_chk_en))
    |-> (trap_valid && trap_type == TT_TAGOFF));

  assert_hold_record_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (dfr_pending && !dfr_ack) |=> (dfr_pending && $stable(dfr_pc)));
endmodule

// File: tb/memtag_unit_bench.sv
module memtag_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_tagset = 0, req_blkinit = 0, req_nofault = 0;
  logic [63:0] req_addr = '0, req_pc = '0;
  logic [31:0] req_wdata = '0;
  logic task_chk_en = 0, page_chk_en = 0, page_writable = 0, precise_mode = 0, dfr_ack = 0;
  logic resp_valid, trap_valid, dfr_pending;
  logic [31:0] resp_rdata;
  logic [1:0] trap_type;
  logic [63:0] trap_addr, dfr_pc;

  int errors = 0;
  int checks = 0;

  int m_tag [16];
  int m_data [16];
  bit m_pend = 0;
  logic [63:0] m_pc = '0;

  always #4 clk = ~clk;

  memtag_unit u_memtag_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_store(req_store), .req_tagset(req_tagset), .req_blkinit(req_blkinit),
    .req_nofault(req_nofault), .req_wdata(req_wdata), .req_pc(req_pc),
    .task_chk_en(task_chk_en), .page_chk_en(page_chk_en), .page_writable(page_writable),
    .precise_mode(precise_mode), .dfr_ack(dfr_ack), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .trap_valid(trap_valid), .trap_type(trap_type),
    .trap_addr(trap_addr), .dfr_pending(dfr_pending), .dfr_pc(dfr_pc));

  function automatic logic [63:0] mk(input int tg, input int ix);
    return {tg[3:0], 50'd0, ix[3:0], 6'h15};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic compare(input string rq, input bit e_rv, input logic [31:0] e_rd,
                         input bit e_tv, input logic [1:0] e_tt, input logic [63:0] e_ta);
    check(resp_valid === e_rv, rq, "resp_valid", 64'(resp_valid), 64'(e_rv));
    check(resp_rdata === e_rd, rq, "resp_rdata", 64'(resp_rdata), 64'(e_rd));
    check(trap_valid === e_tv, rq, "trap_valid", 64'(trap_valid), 64'(e_tv));
    check(trap_type === e_tt, rq, "trap_type", 64'(trap_type), 64'(e_tt));
    check(trap_addr === e_ta, rq, "trap_addr", trap_addr, e_ta);
    check(dfr_pending === m_pend, rq, "dfr_pending", 64'(dfr_pending), 64'(m_pend));
    check(dfr_pc === m_pc, rq, "dfr_pc", dfr_pc, m_pc);
  endtask

  // kind: 0 load, 1 store, 2 tag-set, 3 block-init, 4 non-faulting load
  task automatic op(input int kind, input int tg, input int ix, input int wd,
                    input int pc, input bit ack, input string rq);
    logic [63:0] a;
    bit chk, wild, mm, e_tv, dcap;
    logic [1:0] e_tt;
    logic [31:0] e_rd;
    int st;
    a = mk(tg, ix);
    req_valid = 1; req_addr = a; req_wdata = wd; req_pc = 64'(pc); dfr_ack = ack;
    req_store = (kind == 1); req_tagset = (kind == 2); req_blkinit = (kind == 3);
    req_nofault = (kind == 4);
    st = m_tag[ix];
    chk = task_chk_en && page_chk_en;
    wild = (tg == 0) || (tg == 15) || (st == 0) || (st == 15);
    mm = chk && !wild && (tg != st);
    e_tv = 0; e_tt = 0; e_rd = 0; dcap = 0;
    case (kind)
      2: if (!task_chk_en) begin e_tv = 1; e_tt = 2; end
         else if (!page_writable) begin e_tv = 1; e_tt = 3; end
         else m_tag[ix] = wd & 15;
      3: begin m_tag[ix] = 0; m_data[ix] = 0; end
      1: if (mm && precise_mode) begin e_tv = 1; e_tt = 1; end
         else begin
           m_data[ix] = wd;
           if (mm && (!m_pend || ack)) dcap = 1;
         end
      default: if (kind == 0 && mm) begin e_tv = 1; e_tt = 1; end
               else e_rd = m_data[ix];
    endcase
    @(posedge clk);
    if (dcap) begin m_pend = 1; m_pc = 64'(pc); end
    else if (ack) m_pend = 0;
    @(negedge clk);
    req_valid = 0; dfr_ack = 0;
    compare(rq, 1'b1, e_rd, e_tv, e_tt, e_tv ? a : 64'd0);
  endtask

  task automatic idle(input bit ack, input string rq);
    req_valid = 0; dfr_ack = ack;
    @(posedge clk);
    if (ack) m_pend = 0;
    @(negedge clk);
    dfr_ack = 0;
    compare(rq, 1'b0, 32'd0, 1'b0, 2'd0, 64'd0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_tag[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1", 1'b0, 32'd0, 1'b0, 2'd0, 64'd0);
    task_chk_en = 1; page_chk_en = 1; page_writable = 1;
    for (int i = 0; i < 16; i++) op(0, 5, i, 0, 0, 0, "R1");

    op(2, 0, 3, 10, 0, 0, "R9");
    op(0, 10, 3, 0, 0, 0, "R2");
    op(0, 5, 3, 0, 0, 0, "R5");
    precise_mode = 1;
    op(0, 5, 3, 0, 0, 0, "R5");
    precise_mode = 0;
    op(0, 5, 4, 0, 0, 0, "R9");
    op(0, 15, 3, 0, 0, 0, "R4");
    op(0, 0, 3, 0, 0, 0, "R4");
    op(2, 0, 6, 15, 0, 0, "R4");
    op(0, 7, 6, 0, 0, 0, "R4");

    op(1, 10, 3, 32'h1234, 0, 0, "R2");
    op(0, 10, 3, 0, 0, 0, "R2");
    op(4, 5, 3, 0, 0, 0, "R8");

    page_chk_en = 0;
    op(0, 5, 3, 0, 0, 0, "R3");
    op(1, 5, 3, 32'h55, 0, 0, "R3");
    page_chk_en = 1; task_chk_en = 0;
    op(0, 5, 3, 0, 0, 0, "R3");
    task_chk_en = 1;

    precise_mode = 1;
    op(1, 5, 3, 32'hdead, 0, 0, "R7");
    op(0, 10, 3, 0, 0, 0, "R7");
    precise_mode = 0;

    op(1, 5, 3, 32'hbeef, 100, 0, "R6");
    op(0, 10, 3, 0, 0, 0, "R6");
    op(1, 6, 3, 32'h77, 200, 0, "R13");
    idle(0, "R13");
    idle(1, "R13");
    op(1, 5, 3, 32'h88, 300, 0, "R13");
    op(1, 5, 3, 32'h99, 400, 1, "R13");
    idle(0, "R13");
    op(1, 10, 3, 32'h11, 500, 1, "R13");

    task_chk_en = 0;
    op(2, 0, 3, 7, 0, 0, "R10");
    task_chk_en = 1;
    op(0, 5, 3, 0, 0, 0, "R10");
    page_writable = 0;
    op(2, 0, 3, 7, 0, 0, "R11");
    op(0, 7, 3, 0, 0, 0, "R11");
    page_writable = 1;

    op(3, 7, 3, 0, 0, 0, "R12");
    op(0, 5, 3, 0, 0, 0, "R12");

    op(2, 9, 5, 6, 0, 0, "R9");
    op(0, 6, 5, 0, 0, 0, "R9");
    op(0, 9, 5, 0, 0, 0, "R9");

    for (int k = 0; k < 60; k++)
      op(k % 5, (k * 7) % 16, (k * 3) % 16, k * 13, 1000 + k, (k % 9) == 0, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule